// File: doc/BRIEF.md
# Accumulator-MQ Shift and Transfer Unit

This block is an extended-arithmetic datapath for an 18-bit machine. It holds an accumulator (AC) and a multiplier-quotient register (MQ). It executes one instruction word at a time, taken from `instr_i` on a `start_i` strobe. Three kinds of work are supported: shifts of the 36-bit AC:MQ pair in either direction, left shifts of AC alone, and register-transfer micro-operations between AC and MQ. The micro-operations can be merged by OR-ing their bits into one word.

Shifts move one bit per clock under a step counter. While an instruction runs, `busy_o` is high. A single-cycle `done_o` pulse marks completion. The two registers can be preset from `ac_i` and `mq_i` with `load_i` while the unit is idle, and they are always visible on `ac_o` and `mq_o`. Bit positions below use `[17:0]`, where bit 17 has octal weight 400000.

Top module: `acmq_shift_unit`

## Requirements
- R1: After reset, AC and MQ are zero and busy_o and done_o are low.
- R2: When the unit is idle and start_i is low, load_i writes ac_i into AC and mq_i into MQ on the clock edge.
- R3: Selector bits [8:6]=5 select a long right shift of AC:MQ. Each step moves AC bit 0 into MQ bit 17. The vacated AC bit 17 is refilled with the original AC sign when bit 13 is set, and with zero when it is clear.
- R4: Selector 6 selects a long left shift of AC:MQ. Each step moves MQ bit 17 into AC bit 0 and fills MQ bit 0 with zero. With bit 13 set, AC bit 17 is held and the shift runs below it.
- R5: Selector 7 shifts AC alone to the left with zero fill, and MQ is unchanged. With bit 13 set, AC bit 17 is held.
- R6: The step count is bits [5:0]. A count of zero leaves both registers unchanged. A count of N is applied as N single-bit steps, so counts of 36 or more flush the pair completely. done_o is high for exactly one cycle, N clock edges after the start edge (on the cycle right after the start edge when N is 0).
- R7: Selector 0 is a transfer word, applied in one cycle, and every term reads the values held before the instruction. The terms are:
  - bit 9 clears AC;
  - bit 1 ORs MQ into AC;
  - bit 12 clears MQ;
  - bit 10 ORs AC into MQ, after any clear;
  - bit 2 sets MQ to the complement of its old value, overriding bits 12 and 10.
- R8: From the start edge until done_o, busy_o is high, and start_i and load_i are ignored.
- R9: Merged words behave as the sum of their terms. 0641002 copies MQ into AC. 0652000 copies AC into MQ. 0650002 ORs MQ into AC and leaves MQ zero. 0653002 swaps AC and MQ.
- R10: A word is accepted only if bits [17:14] are 1101 and bit 11 is 0. Any other word on start_i has no effect and raises neither busy_o nor done_o. An accepted word with selector 1 to 4 completes with done_o and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin executing instr_i |
| instr_i | input | 18 | Instruction word |
| load_i | input | 1 | Preset AC and MQ while idle |
| ac_i | input | 18 | Preset value for AC |
| mq_i | input | 18 | Preset value for MQ |
| ac_o | output | 18 | Accumulator |
| mq_o | output | 18 | Multiplier-quotient register |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default word width of 18 and a 6-bit count field. At those values the maximum step count of 63 exceeds the 36-bit pair, so full flushes and sign smearing can be reached next to the zero-count case. A scoreboard predicts each result and each done cycle from a bit-serial model of the requirements. It then checks merged transfer words, starts and loads attempted mid-shift, and words outside the group.

// File: rtl/acmq_pkg.sv
package acmq_pkg;
  typedef enum logic [2:0] {
    K_NOP  = 3'd0,
    K_XFER = 3'd1,
    K_LRS  = 3'd2,
    K_LLS  = 3'd3,
    K_ALS  = 3'd4
  } kind_e;

  typedef struct packed {
    logic clr_ac;
    logic or_mq;
    logic clr_mq;
    logic or_ac;
    logic cmp_mq;
  } xfer_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_SHIFT = 2'd1,
    S_FIN   = 2'd2
  } state_e;
endpackage

// File: rtl/acmq_decode.sv
module acmq_decode
  import acmq_pkg::*;
#(
  parameter int W     = 18,
  parameter int CNT_W = 6
) (
  input  logic [W-1:0]     instr_i,
  output logic             valid_o,
  output kind_e            kind_o,
  output logic             sgn_o,
  output logic [CNT_W-1:0] cnt_o,
  output xfer_t            xfer_o
);
  localparam int GRP_LO = W - 4;
  localparam int SGN_B  = W - 5;
  localparam int CMQ_B  = W - 6;
  localparam int RSV_B  = W - 7;
  localparam int OAC_B  = W - 8;
  localparam int CAC_B  = W - 9;

  logic [2:0] sel;
  assign sel = instr_i[8:6];

  assign valid_o = (instr_i[W-1:GRP_LO] == 4'b1101) && !instr_i[RSV_B];
  assign sgn_o   = instr_i[SGN_B];
  assign cnt_o   = instr_i[CNT_W-1:0];

  always_comb begin
    unique case (sel)
      3'd0:    kind_o = K_XFER;
      3'd5:    kind_o = K_LRS;
      3'd6:    kind_o = K_LLS;
      3'd7:    kind_o = K_ALS;
      default: kind_o = K_NOP;
    endcase
  end

  assign xfer_o.clr_ac = instr_i[CAC_B];
  assign xfer_o.or_mq  = instr_i[1];
  assign xfer_o.clr_mq = instr_i[CMQ_B];
  assign xfer_o.or_ac  = instr_i[OAC_B];
  assign xfer_o.cmp_mq = instr_i[2];
endmodule

// File: rtl/acmq_step.sv
module acmq_step
  import acmq_pkg::*;
#(
  parameter int W = 18
) (
  input  kind_e        kind_i,
  input  logic         sgn_i,
  input  logic [W-1:0] ac_i,
  input  logic [W-1:0] mq_i,
  output logic [W-1:0] ac_o,
  output logic [W-1:0] mq_o
);
  logic fill;
  assign fill = sgn_i & ac_i[W-1];

  always_comb begin
    ac_o = ac_i;
    mq_o = mq_i;
    unique case (kind_i)
      K_LRS: begin
        ac_o = {fill, ac_i[W-1:1]};
        mq_o = {ac_i[0], mq_i[W-1:1]};
      end
      K_LLS: begin
        ac_o = sgn_i ? {ac_i[W-1], ac_i[W-3:0], mq_i[W-1]}
                     : {ac_i[W-2:0], mq_i[W-1]};
        mq_o = {mq_i[W-2:0], 1'b0};
      end
      K_ALS: begin
        ac_o = sgn_i ? {ac_i[W-1], ac_i[W-3:0], 1'b0}
                     : {ac_i[W-2:0], 1'b0};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acmq_xfer.sv
module acmq_xfer
  import acmq_pkg::*;
#(
  parameter int W = 18
) (
  input  xfer_t        op_i,
  input  logic [W-1:0] ac_i,
  input  logic [W-1:0] mq_i,
  output logic [W-1:0] ac_o,
  output logic [W-1:0] mq_o
);
  logic [W-1:0] mq_base;

  // clear precedes the OR-in of AC
  assign mq_base = (op_i.clr_mq ? '0 : mq_i) | (op_i.or_ac ? ac_i : '0);
  assign ac_o    = (op_i.clr_ac ? '0 : ac_i) | (op_i.or_mq ? mq_i : '0);
  assign mq_o    = op_i.cmp_mq ? ~mq_i : mq_base;
endmodule

// File: rtl/acmq_shift_unit.sv
module acmq_shift_unit
  import acmq_pkg::*;
#(
  parameter int W     = 18,
  parameter int CNT_W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] instr_i,
  input  logic         load_i,
  input  logic [W-1:0] ac_i,
  input  logic [W-1:0] mq_i,
  output logic [W-1:0] ac_o,
  output logic [W-1:0] mq_o,
  output logic         busy_o,
  output logic         done_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  state_e           st_q;
  logic [W-1:0]     ac_q, mq_q;
  logic [CNT_W-1:0] cnt_q;
  kind_e            kind_q;
  logic             sgn_q;

  logic             dec_valid, dec_sgn;
  kind_e            dec_kind;
  logic [CNT_W-1:0] dec_cnt;
  xfer_t            dec_xfer;
  logic [W-1:0]     x_ac, x_mq, s_ac, s_mq;
  logic             dec_shift;

  acmq_decode #(.W(W), .CNT_W(CNT_W)) u_dec (
    .instr_i (instr_i),
    .valid_o (dec_valid),
    .kind_o  (dec_kind),
    .sgn_o   (dec_sgn),
    .cnt_o   (dec_cnt),
    .xfer_o  (dec_xfer)
  );

  acmq_xfer #(.W(W)) u_xfer (
    .op_i (dec_xfer),
    .ac_i (ac_q),
    .mq_i (mq_q),
    .ac_o (x_ac),
    .mq_o (x_mq)
  );

  acmq_step #(.W(W)) u_step (
    .kind_i (kind_q),
    .sgn_i  (sgn_q),
    .ac_i   (ac_q),
    .mq_i   (mq_q),
    .ac_o   (s_ac),
    .mq_o   (s_mq)
  );

  assign dec_shift = (dec_kind == K_LRS) || (dec_kind == K_LLS) || (dec_kind == K_ALS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      ac_q   <= '0;
      mq_q   <= '0;
      cnt_q  <= '0;
      kind_q <= K_NOP;
      sgn_q  <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (start_i && dec_valid) begin
            kind_q <= dec_kind;
            sgn_q  <= dec_sgn;
            cnt_q  <= dec_cnt;
            if (dec_kind == K_XFER) begin
              ac_q <= x_ac;
              mq_q <= x_mq;
            end
            st_q <= (dec_shift && dec_cnt != '0) ? S_SHIFT : S_FIN;
          end else if (load_i && !start_i) begin
            ac_q <= ac_i;
            mq_q <= mq_i;
          end
        end
        S_SHIFT: begin
          ac_q  <= s_ac;
          mq_q  <= s_mq;
          cnt_q <= cnt_q - CNT_ONE;
          if (cnt_q == CNT_ONE) st_q <= S_FIN;
        end
        S_FIN:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ac_o   = ac_q;
  assign mq_o   = mq_q;
  assign busy_o = (st_q != S_IDLE);
  assign done_o = (st_q == S_FIN);

  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_lrs_sign_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SHIFT && kind_q == K_LRS && sgn_q) |=> ac_q[W-1] == $past(ac_q[W-1]));

  assert_als_mq_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SHIFT && kind_q == K_ALS) |=> $stable(mq_q));

  assert_busy_ignores_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SHIFT && start_i) |=> $stable(kind_q) && $stable(sgn_q));

  assert_fin_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_FIN) |=> $stable(ac_q) && $stable(mq_q));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && !load_i && !(start_i && dec_valid)) |=> $stable(ac_q) && $stable(mq_q) && !busy_o);
endmodule

// File: tb/acmq_shift_unit_test.sv
module acmq_shift_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, load = 1'b0;
  logic [17:0] instr = '0, ac_in = '0, mq_in = '0;
  logic [17:0] ac_o, mq_o;
  logic busy_o, done_o;

  int total = 0, bad = 0, cyc = 0;
  logic [17:0] m_ac = '0, m_mq = '0;

  typedef struct {
    logic [35:0] val;
    int          when;
    string       tag;
  } exp_t;
  exp_t q[$];

  acmq_shift_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr),
    .load_i(load), .ac_i(ac_in), .mq_i(mq_in),
    .ac_o(ac_o), .mq_o(mq_o), .busy_o(busy_o), .done_o(done_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%012o exp=%012o", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] model(input logic [17:0] a, input logic [17:0] m, input logic [17:0] ins);
    logic [35:0] t;
    logic [17:0] na, nm;
    logic s0;
    int n;
    t = {a, m};
    s0 = a[17];
    n = int'(ins[5:0]);
    if (ins[17:14] != 4'b1101 || ins[11]) return t;
    case (ins[8:6])
      3'd5: for (int i = 0; i < n; i++) t = {(ins[13] ? s0 : 1'b0), t[35:1]};
      3'd6: for (int i = 0; i < n; i++) t = ins[13] ? {t[35], t[33:0], 1'b0} : {t[34:0], 1'b0};
      3'd7: for (int i = 0; i < n; i++) t[35:18] = ins[13] ? {t[35], t[33:18], 1'b0} : {t[34:18], 1'b0};
      3'd0: begin
        na = (ins[9] ? 18'd0 : a) | (ins[1] ? m : 18'd0);
        nm = ins[2] ? ~m : ((ins[12] ? 18'd0 : m) | (ins[10] ? a : 18'd0));
        t = {na, nm};
      end
      default: ;
    endcase
    return t;
  endfunction

  function automatic int steps(input logic [17:0] ins);
    return (ins[8:6] >= 3'd5) ? int'(ins[5:0]) : 0;
  endfunction

  // monitor: pops expected results on each done pulse
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (q.size() == 0) begin
        check(1'b0, "R10 unexpected done", {ac_o, mq_o}, '0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({ac_o, mq_o} == e.val, e.tag, {ac_o, mq_o}, e.val);
        check(cyc == e.when, {e.tag, " done cycle R6"}, 36'(cyc), 36'(e.when));
      end
    end
  end

  task automatic do_load(input logic [17:0] a, input logic [17:0] m);
    @(negedge clk);
    load = 1'b1; ac_in = a; mq_in = m;
    @(negedge clk);
    load = 1'b0;
    m_ac = a; m_mq = m;
    check({ac_o, mq_o} == {a, m}, "R2 load", {ac_o, mq_o}, {a, m});
  endtask

  task automatic do_op(input logic [17:0] ins, input string tag);
    exp_t e;
    @(negedge clk);
    e.val = model(m_ac, m_mq, ins);
    e.when = cyc + 1 + steps(ins);
    e.tag = tag;
    q.push_back(e);
    start = 1'b1; instr = ins;
    @(negedge clk);
    start = 1'b0;
    while (q.size() != 0) @(posedge clk);
    @(negedge clk);
    check(busy_o == 1'b0, {tag, " busy clear R8"}, 36'(busy_o), 36'd0);
    {m_ac, m_mq} = e.val;
  endtask

  initial begin
    #(20 * 100000);
    check(1'b0, "watchdog", 36'(cyc), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({ac_o, mq_o, busy_o, done_o} == '0, "R1 reset", {ac_o, mq_o}, '0);
    rst_n = 1'b1;

    do_load(18'o612345, 18'o054321);
    do_op(18'o640505, "R3 unsigned right 5");
    do_load(18'o612345, 18'o054321);
    do_op(18'o660505, "R3 signed right 5");
    do_load(18'o400000, 18'o000001);
    do_op(18'o660550, "R6 signed right 40 flush");
    do_load(18'o212345, 18'o654321);
    do_op(18'o640607, "R4 unsigned long left 7");
    do_load(18'o612345, 18'o654321);
    do_op(18'o660607, "R4 signed long left 7");
    do_load(18'o612345, 18'o777777);
    do_op(18'o640703, "R5 unsigned AC left 3");
    do_load(18'o612345, 18'o123456);
    do_op(18'o660703, "R5 signed AC left 3");
    do_op(18'o640600, "R6 zero count");
    do_load(18'o777777, 18'o777777);
    do_op(18'o640677, "R6 long left 63");

    do_load(18'o123456, 18'o070707);
    do_op(18'o641002, "R9 AC from MQ");
    do_load(18'o123456, 18'o070707);
    do_op(18'o650000, "R7 clear MQ");
    do_load(18'o123456, 18'o070707);
    do_op(18'o650002, "R9 OR MQ into AC");
    do_load(18'o123456, 18'o070707);
    do_op(18'o650004, "R7 complement MQ");
    do_load(18'o123456, 18'o070707);
    do_op(18'o652000, "R9 MQ from AC");
    do_load(18'o123456, 18'o070707);
    do_op(18'o653002, "R9 swap");
    do_load(18'o123456, 18'o070707);
    do_op(18'o642000, "R7 OR AC into MQ");
    do_op(18'o640100, "R10 selector 1 no change");

    // busy window: start and load mid-shift are ignored
    do_load(18'o500000, 18'o000000);
    begin
      exp_t e;
      @(negedge clk);
      e.val = model(m_ac, m_mq, 18'o640512);
      e.when = cyc + 1 + 10;
      e.tag = "R8 start/load ignored while busy";
      q.push_back(e);
      start = 1'b1; instr = 18'o640512;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      check(busy_o == 1'b1, "R8 busy during shift", 36'(busy_o), 36'd1);
      start = 1'b1; instr = 18'o650004; load = 1'b1; ac_in = 18'o777777; mq_in = 18'o777777;
      @(negedge clk);
      start = 1'b0; load = 1'b0;
      while (q.size() != 0) @(posedge clk);
      @(negedge clk);
      {m_ac, m_mq} = e.val;
      check({ac_o, mq_o} == e.val, "R8 state after ignored inputs", {ac_o, mq_o}, e.val);
    end

    // words outside the group
    @(negedge clk);
    start = 1'b1; instr = 18'o740001;
    @(negedge clk);
    start = 1'b0;
    check(busy_o == 1'b0, "R10 foreign word not busy", 36'(busy_o), 36'd0);
    @(negedge clk);
    start = 1'b1; instr = 18'o654002;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check({ac_o, mq_o} == {m_ac, m_mq}, "R10 foreign word no effect", {ac_o, mq_o}, {m_ac, m_mq});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule